// File: doc/BRIEF.md
# Dual-Accumulator Fractional Multiply-Accumulate Unit

This block is the arithmetic core of a two-lane multiply-accumulate datapath. On each accepted command, both lanes take two shared 32-bit source words. Each lane picks the upper or lower 16-bit half of each word on its own. It forms a 16x16 product and loads, adds or subtracts that product into its own 40-bit accumulator. Both lanes can act in the same command, and each has its own enable, operation code and half selects.

By default, products are treated as signed fractions and so are doubled. A global integer flag turns the doubling off. Lane 1 also has a mixed-sign option: its first operand is unsigned and its second is signed. Lane 0 can also produce a 16-bit result from its new accumulator value. That result is the upper half of the accumulator's low 32-bit word, cut off without rounding and clamped when the value no longer fits in 32 signed bits. It is merged into the low half of a caller-supplied destination word, and the upper half of that word passes through unchanged. The low 32 bits of each accumulator are visible as ports.

Results appear one clock after the command is accepted. Instruction decoding and the register file sit outside this block.

Top module: `dual_mac`

## Requirements
- R1: While reset is asserted, both accumulators, `dst_out` and `res_valid` are zero.
- R2: Each lane picks its first operand from `src_x` and its second from `src_y`. A select bit of 1 takes bits 31:16 and a select bit of 0 takes bits 15:0, independently for every operand of every lane.
- R3: With `cmd_int`=0, a signed 16x16 product is doubled (shifted left one bit) before accumulation. For example, 0x5ABD times 0xFEC7 loaded into lane 0 gives `acc0_word` 0xFF221DD6.
- R4: The lane operation code is 00 to load the product, 01 to add it and 10 to subtract it. Code 11 leaves the accumulator unchanged. The arithmetic is 40 bits wide and wraps.
- R5: With `cmd_int`=0, the product 0x8000 times 0x8000 is clamped to 0x7FFFFFFF before accumulation.
- R6: With `cmd_int`=1, signed products are not doubled, so 0x8000 times 0x8000 gives 0x40000000.
- R7: With `l1_mixed`=1, lane 1 treats its first operand as unsigned and its second as signed, and does not double the product. For example, 0xFFFF times 0x0002 gives 0x0001FFFE.
- R8: The two lanes update in the same accepted command, each under its own enable. A lane whose enable is 0 keeps its accumulator.
- R9: With `wr_en`=1, `dst_out` is the `dst_in` word with bits 15:0 replaced by bits 31:16 of lane 0's new accumulator, with no rounding. With `wr_en`=0, `dst_out` equals `dst_in`. Bits 31:16 always come from `dst_in`.
- R10: If lane 0's new 40-bit accumulator lies outside the signed 32-bit range, the written 16-bit value is 0x7FFF for a positive value and 0x8000 for a negative one.
- R11: A command given with `cmd_valid`=1 at one rising edge shows on `dst_out`, `acc0_word` and `acc1_word` just after that edge, and `res_valid` is then 1. Without `cmd_valid`, no output or accumulator changes and `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_int | input | 1 | 1 selects integer products, 0 selects fractional products |
| src_x | input | 32 | First source word |
| src_y | input | 32 | Second source word |
| dst_in | input | 32 | Current destination word |
| l0_en | input | 1 | Lane 0 accumulator update enable |
| l0_op | input | 2 | Lane 0 operation code |
| l0_x_hi | input | 1 | Lane 0 first operand half select |
| l0_y_hi | input | 1 | Lane 0 second operand half select |
| l1_en | input | 1 | Lane 1 accumulator update enable |
| l1_op | input | 2 | Lane 1 operation code |
| l1_x_hi | input | 1 | Lane 1 first operand half select |
| l1_y_hi | input | 1 | Lane 1 second operand half select |
| l1_mixed | input | 1 | Lane 1 unsigned-by-signed mode |
| wr_en | input | 1 | Write the lane 0 result half into the destination |
| res_valid | output | 1 | Result registered this cycle |
| dst_out | output | 32 | Updated destination word |
| acc0_word | output | 32 | Low 32 bits of lane 0 accumulator |
| acc1_word | output | 32 | Low 32 bits of lane 1 accumulator |

## Verification
The assertions check the time relations on every cycle. They cover the one-cycle result strobe, the pass-through of the destination's upper half and of the whole word when no write is requested, the holding of state while idle or under the keep code, the load of a product, and the agreement of the written half with either the new accumulator word or a clamp value. The arithmetic values themselves can only be shown by the bench's scenarios. These are the doubled fractional products, the 0x8000 squared clamp, the integer and mixed-sign products, add and subtract chains, and the saturated extraction once the guard bits are in use. The bench compares each of them against an independent model and against fixed known results.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD = 2'b00,
    ACC_ADD  = 2'b01,
    ACC_SUB  = 2'b10,
    ACC_KEEP = 2'b11
  } acc_op_e;

endpackage

// File: rtl/dmac_prod.sv
// Product generator for one lane: signed fractional, signed integer or
// unsigned-by-signed, sign-extended to accumulator width.
module dmac_prod #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic [OP_W-1:0]  opa,
  input  logic [OP_W-1:0]  opb,
  input  logic             int_mode,
  input  logic             mixed,
  output logic [ACC_W-1:0] prod
);

  localparam int PW   = 2 * OP_W;
  localparam int EXT  = ACC_W - PW;
  localparam int EXTM = ACC_W - PW - 1;

  logic [PW-1:0] sa, sb, ss_prod, frac_prod;
  logic [PW:0]   ua, ub, us_prod;
  logic          min_sq;

  assign sa      = {{OP_W{opa[OP_W-1]}}, opa};
  assign sb      = {{OP_W{opb[OP_W-1]}}, opb};
  assign ss_prod = sa * sb;

  assign ua      = {{(OP_W+1){1'b0}}, opa};
  assign ub      = {{(OP_W+1){opb[OP_W-1]}}, opb};
  assign us_prod = ua * ub;

  assign min_sq  = (opa == {1'b1, {(OP_W-1){1'b0}}}) &&
                   (opb == {1'b1, {(OP_W-1){1'b0}}});

  always_comb begin
    if (min_sq) begin
      frac_prod = {1'b0, {(PW-1){1'b1}}};
    end else begin
      frac_prod = {ss_prod[PW-2:0], 1'b0};
    end
  end

  always_comb begin
    if (mixed) begin
      prod = {{EXTM{us_prod[PW]}}, us_prod};
    end else if (int_mode) begin
      prod = {{EXT{ss_prod[PW-1]}}, ss_prod};
    end else begin
      prod = {{EXT{frac_prod[PW-1]}}, frac_prod};
    end
  end

endmodule

// File: rtl/dmac_trunc.sv
// Saturating truncation of an accumulator to its upper result half.
module dmac_trunc #(
  parameter int ACC_W  = 40,
  parameter int WORD_W = 32
) (
  input  logic [ACC_W-WORD_W/2-1:0] acc_hi,
  output logic [WORD_W/2-1:0]       half
);

  localparam int HW  = WORD_W / 2;
  localparam int TOP = ACC_W - HW - 1;
  localparam int SGN = WORD_W - 1 - HW;

  logic in_range;

  assign in_range = (&acc_hi[TOP:SGN]) | ~(|acc_hi[TOP:SGN]);

  always_comb begin
    if (in_range) begin
      half = acc_hi[HW-1:0];
    end else if (acc_hi[TOP]) begin
      half = {1'b1, {(HW-1){1'b0}}};
    end else begin
      half = {1'b0, {(HW-1){1'b1}}};
    end
  end

endmodule

// File: rtl/dmac_acc.sv
// One 40-bit accumulator with its op decode and result extraction.
module dmac_acc
  import dmac_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd,
  input  acc_op_e             op,
  input  logic [ACC_W-1:0]    prod,
  output logic [WORD_W-1:0]   acc_word,
  output logic [WORD_W/2-1:0] trunc_half
);

  localparam int HW = WORD_W / 2;

  logic [ACC_W-1:0] acc_q, acc_nxt;

  always_comb begin
    acc_nxt = acc_q;
    if (upd) begin
      unique case (op)
        ACC_LOAD: acc_nxt = prod;
        ACC_ADD:  acc_nxt = acc_q + prod;
        ACC_SUB:  acc_nxt = acc_q - prod;
        default:  acc_nxt = acc_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (upd) begin
      acc_q <= acc_nxt;
    end
  end

  dmac_trunc #(.ACC_W(ACC_W), .WORD_W(WORD_W)) u_trunc (
    .acc_hi (acc_nxt[ACC_W-1:HW]),
    .half   (trunc_half)
  );

  assign acc_word = acc_q[WORD_W-1:0];

  // R11
  acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> acc_q == $past(acc_q));

  // R4
  acc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && op == ACC_KEEP) |=> $stable(acc_q));

  // R4
  acc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && op == ACC_LOAD) |=> acc_q == $past(prod));

endmodule

// File: rtl/dual_mac.sv
module dual_mac
  import dmac_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ACC_W  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_int,
  input  logic [WORD_W-1:0] src_x,
  input  logic [WORD_W-1:0] src_y,
  input  logic [WORD_W-1:0] dst_in,
  input  logic              l0_en,
  input  logic [1:0]        l0_op,
  input  logic              l0_x_hi,
  input  logic              l0_y_hi,
  input  logic              l1_en,
  input  logic [1:0]        l1_op,
  input  logic              l1_x_hi,
  input  logic              l1_y_hi,
  input  logic              l1_mixed,
  input  logic              wr_en,
  output logic              res_valid,
  output logic [WORD_W-1:0] dst_out,
  output logic [WORD_W-1:0] acc0_word,
  output logic [WORD_W-1:0] acc1_word
);

  localparam int OP_W     = WORD_W / 2;
  localparam int NLANE    = 2;
  localparam int DST_LANE = 0;

  logic              ln_en  [NLANE];
  logic [1:0]        ln_op  [NLANE];
  logic              ln_xhi [NLANE];
  logic              ln_yhi [NLANE];
  logic              ln_mix [NLANE];
  logic [WORD_W-1:0] ln_word[NLANE];
  logic [OP_W-1:0]   ln_half[NLANE];

  assign ln_en[0]  = l0_en;
  assign ln_op[0]  = l0_op;
  assign ln_xhi[0] = l0_x_hi;
  assign ln_yhi[0] = l0_y_hi;
  assign ln_mix[0] = 1'b0;
  assign ln_en[1]  = l1_en;
  assign ln_op[1]  = l1_op;
  assign ln_xhi[1] = l1_x_hi;
  assign ln_yhi[1] = l1_y_hi;
  assign ln_mix[1] = l1_mixed;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic [OP_W-1:0]  opa, opb;
    logic [ACC_W-1:0] prod;

    assign opa = ln_xhi[i] ? src_x[WORD_W-1:OP_W] : src_x[OP_W-1:0];
    assign opb = ln_yhi[i] ? src_y[WORD_W-1:OP_W] : src_y[OP_W-1:0];

    dmac_prod #(.OP_W(OP_W), .ACC_W(ACC_W)) u_prod (
      .opa      (opa),
      .opb      (opb),
      .int_mode (cmd_int),
      .mixed    (ln_mix[i]),
      .prod     (prod)
    );

    dmac_acc #(.ACC_W(ACC_W), .WORD_W(WORD_W)) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .upd        (cmd_valid & ln_en[i]),
      .op         (acc_op_e'(ln_op[i])),
      .prod       (prod),
      .acc_word   (ln_word[i]),
      .trunc_half (ln_half[i])
    );
  end

  logic [WORD_W-1:0] dst_nxt, dst_q;
  logic              vld_q;

  always_comb begin
    if (wr_en) begin
      dst_nxt = {dst_in[WORD_W-1:OP_W], ln_half[DST_LANE]};
    end else begin
      dst_nxt = dst_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= cmd_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q <= '0;
    end else if (cmd_valid) begin
      dst_q <= dst_nxt;
    end
  end

  assign res_valid = vld_q;
  assign dst_out   = dst_q;
  assign acc0_word = ln_word[0];
  assign acc1_word = ln_word[1];

  // R11
  res_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> res_valid);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (!res_valid && $stable(dst_out)));

  // R9
  keep_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> dst_out[WORD_W-1:OP_W] == $past(dst_in[WORD_W-1:OP_W]));

  // R9
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !wr_en) |=> dst_out == $past(dst_in));

  // R10
  half_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && wr_en) |=>
      (dst_out[OP_W-1:0] == acc0_word[WORD_W-1:OP_W] ||
       dst_out[OP_W-1:0] == {1'b0, {(OP_W-1){1'b1}}} ||
       dst_out[OP_W-1:0] == {1'b1, {(OP_W-1){1'b0}}}));

endmodule

// File: tb/dual_mac_tb.sv
module dual_mac_tb;

  localparam logic [1:0] LD = 2'b00;
  localparam logic [1:0] AD = 2'b01;
  localparam logic [1:0] SB = 2'b10;
  localparam logic [1:0] KP = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_int = 1'b0;
  logic [31:0] src_x = '0, src_y = '0, dst_in = '0;
  logic        l0_en = 1'b0, l0_x_hi = 1'b0, l0_y_hi = 1'b0;
  logic [1:0]  l0_op = 2'b00, l1_op = 2'b00;
  logic        l1_en = 1'b0, l1_x_hi = 1'b0, l1_y_hi = 1'b0, l1_mixed = 1'b0;
  logic        wr_en = 1'b0;
  logic        res_valid;
  logic [31:0] dst_out, acc0_word, acc1_word;

  int checks = 0;
  int failures = 0;

  typedef struct packed {
    logic [31:0] dst;
    logic [31:0] a0;
    logic [31:0] a1;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  logic [39:0] m_acc0 = '0, m_acc1 = '0;

  always #5 clk = ~clk;

  dual_mac u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_int(cmd_int),
    .src_x(src_x), .src_y(src_y), .dst_in(dst_in),
    .l0_en(l0_en), .l0_op(l0_op), .l0_x_hi(l0_x_hi), .l0_y_hi(l0_y_hi),
    .l1_en(l1_en), .l1_op(l1_op), .l1_x_hi(l1_x_hi), .l1_y_hi(l1_y_hi),
    .l1_mixed(l1_mixed), .wr_en(wr_en), .res_valid(res_valid),
    .dst_out(dst_out), .acc0_word(acc0_word), .acc1_word(acc1_word)
  );

  function automatic logic [39:0] f_prod(logic [15:0] a, logic [15:0] b,
                                         logic im, logic mx);
    longint pa, pb, p;
    pa = mx ? longint'(a) : longint'($signed(a));
    pb = longint'($signed(b));
    p  = pa * pb;
    if (!mx && !im) begin
      if (a == 16'h8000 && b == 16'h8000) p = 64'sh7FFFFFFF;
      else p = p * 2;
    end
    return p[39:0];
  endfunction

  function automatic logic [39:0] f_step(logic [39:0] acc, logic [1:0] op,
                                         logic [39:0] p);
    case (op)
      LD:      return p;
      AD:      return acc + p;
      SB:      return acc - p;
      default: return acc;
    endcase
  endfunction

  function automatic logic [15:0] f_ext(logic [39:0] acc);
    longint v;
    v = longint'($signed(acc));
    if (v > 64'sd2147483647) return 16'h7FFF;
    if (v < -64'sd2147483648) return 16'h8000;
    return acc[31:16];
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Driver: updates the model, queues the expected result, drives the command.
  task automatic issue(input logic [31:0] x, y, d,
                       input logic e0, input logic [1:0] o0, input logic xh0, yh0,
                       input logic e1, input logic [1:0] o1, input logic xh1, yh1,
                       input logic mx, input logic im, input logic wr,
                       input string tag);
    logic [39:0] p0, p1;
    exp_t e;
    p0 = f_prod(xh0 ? x[31:16] : x[15:0], yh0 ? y[31:16] : y[15:0], im, 1'b0);
    p1 = f_prod(xh1 ? x[31:16] : x[15:0], yh1 ? y[31:16] : y[15:0], im, mx);
    if (e0) m_acc0 = f_step(m_acc0, o0, p0);
    if (e1) m_acc1 = f_step(m_acc1, o1, p1);
    e.dst = wr ? {d[31:16], f_ext(m_acc0)} : d;
    e.a0  = m_acc0[31:0];
    e.a1  = m_acc1[31:0];
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    src_x = x; src_y = y; dst_in = d;
    l0_en = e0; l0_op = o0; l0_x_hi = xh0; l0_y_hi = yh0;
    l1_en = e1; l1_op = o1; l1_x_hi = xh1; l1_y_hi = yh1;
    l1_mixed = mx; cmd_int = im; wr_en = wr; cmd_valid = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
    end
  endtask

  // Monitor: pops one expected item per result strobe.
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R11 actual=unexpected_result expected=no_result");
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " dst"}, dst_out, e.dst);
        check({t, " acc0"}, acc0_word, e.a0);
        check({t, " acc1"}, acc1_word, e.a1);
      end
    end
  end

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 res_valid", {31'd0, res_valid}, 32'd0);
    check("R1 dst_out", dst_out, 32'd0);
    check("R1 acc0", acc0_word, 32'd0);
    check("R1 acc1", acc1_word, 32'd0);
    rst_n = 1'b1;
    idle(2);

    // R3 R9: lo*lo fractional, truncated half into low destination half
    issue(32'hA3545ABD, 32'hBDBCFEC7, 32'hA3545ABD,
          1, LD, 0, 0, 1, LD, 0, 0, 0, 0, 1, "R3");
    idle(1);
    // R11 result one edge after acceptance
    check("R11 strobe", {31'd0, res_valid}, 32'd1);
    check("R3 known acc0", acc0_word, 32'hFF221DD6);
    check("R9 known dst", dst_out, 32'hA354FF22);

    // R2 R8: hi/lo picks, both lanes, lane 1 subtracts
    issue(32'hC1248679, 32'hD0069007, 32'hC1248679,
          1, LD, 1, 0, 1, SB, 0, 1, 0, 0, 1, "R2");
    idle(1);
    check("R2 known acc0", acc0_word, 32'hC1248679 == 32'hC1248679 ? 32'h36FD0FF8 : 32'h0);
    check("R2 known dst", dst_out, 32'hC12436FD);

    // R4 add chain hi*hi
    issue(32'hEFBC4569, 32'hCD35500B, 32'hEFBC4569,
          1, AD, 1, 1, 1, SB, 1, 0, 0, 0, 1, "R4 add");
    idle(1);
    check("R4 known acc0", acc0_word, 32'h3D716BD0);
    check("R4 known dst", dst_out, 32'hEFBC3D71);
    held = acc0_word;
    idle(3);
    // R11 no command: nothing moves
    check("R11 idle strobe", {31'd0, res_valid}, 32'd0);
    check("R11 idle acc0", acc0_word, held);

    // R4 subtract, keep code, R8 disabled lane
    issue(32'h12345678, 32'h9ABCDEF0, 32'h0000FFFF,
          1, SB, 0, 1, 1, AD, 1, 0, 0, 0, 1, "R4 sub");
    issue(32'h7FFF0001, 32'h00030004, 32'h55550000,
          1, KP, 1, 1, 1, LD, 0, 0, 0, 0, 1, "R4 keep");
    issue(32'h40004000, 32'h20002000, 32'hAAAA1111,
          0, LD, 1, 1, 1, AD, 1, 1, 0, 0, 1, "R8 lane0 off");
    issue(32'h40004000, 32'h20002000, 32'hAAAA1111,
          1, LD, 0, 0, 0, LD, 0, 0, 0, 0, 1, "R8 lane1 off");

    // R5 min squared fractional, R6 integer
    issue(32'h80000000, 32'h00008000, 32'h11112222,
          1, LD, 1, 0, 1, LD, 1, 0, 0, 0, 1, "R5");
    idle(1);
    check("R5 known acc0", acc0_word, 32'h7FFFFFFF);
    issue(32'h80000000, 32'h00008000, 32'h11112222,
          1, LD, 1, 0, 1, LD, 1, 0, 0, 1, 1, "R6");
    idle(1);
    check("R6 known acc0", acc0_word, 32'h40000000);

    // R7 mixed sign on lane 1
    issue(32'h0000FFFF, 32'h00000002, 32'h0,
          1, LD, 0, 0, 1, LD, 0, 0, 1, 0, 1, "R7");
    idle(1);
    check("R7 known acc1", acc1_word, 32'h0001FFFE);
    check("R7 lane0 signed", acc0_word, 32'hFFFFFFFC);

    // R10 positive and negative saturation
    issue(32'h7FFF7FFF, 32'h7FFF7FFF, 32'hBEEF0000,
          1, LD, 1, 1, 1, LD, 0, 0, 0, 0, 1, "R10 pos load");
    issue(32'h7FFF7FFF, 32'h7FFF7FFF, 32'hBEEF0000,
          1, AD, 1, 1, 1, AD, 0, 0, 0, 0, 1, "R10 pos sat");
    idle(1);
    check("R10 pos clamp", dst_out, 32'hBEEF7FFF);
    issue(32'h80008000, 32'h7FFF7FFF, 32'hCAFE0000,
          1, LD, 0, 0, 1, SB, 0, 0, 0, 0, 1, "R10 neg load");
    issue(32'h80008000, 32'h7FFF7FFF, 32'hCAFE0000,
          1, AD, 0, 0, 1, SB, 0, 0, 0, 0, 1, "R10 neg sat");
    idle(1);
    check("R10 neg clamp", dst_out, 32'hCAFE8000);

    // R9 write disabled passes destination through
    issue(32'h11111111, 32'h22222222, 32'h12345678,
          1, AD, 0, 0, 1, AD, 1, 1, 0, 0, 0, "R9 no write");
    idle(1);
    check("R9 passthrough", dst_out, 32'h12345678);
    idle(3);

    check("R11 queue drained", exp_q.size(), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule